// File: doc/BRIEF.md
# Sub-word Register Window Adapter

This block sits between a byte-addressed 128-byte I/O window and three register targets that accept only whole 32-bit words. The three targets are a 16-word SCSI core bank, an 8-word DMA bank and a single bus-and-control word. A host access can be 1, 2 or 4 bytes wide and can start at any byte offset. The adapter converts each access into word operations that the targets can accept.

Reads fetch the aligned word, shift it down to the access offset and trim it to the access size. A 4-byte aligned write passes straight through. A narrower or offset write first reads the current target word, then replaces only the addressed byte lanes, then writes the whole word back in the following cycle. Data is little-endian: byte k of the host data goes to byte lane offset+k. An access with an illegal size, or one that runs past a word boundary, is completed with an error flag and touches no target.

The host holds `hostReq` and its fields steady until `hostReady` pulses. Targets return `tgtRdata` combinationally in the same cycle as `tgtRd`.

Top module: `subword_window_adapter`

## Requirements
- R1: Offsets below 0x40 select the core bank (`tgtSel` = 1) at index offset[5:2].
- R2: Offsets 0x40 to 0x5F select the DMA bank (`tgtSel` = 2) at index (offset − 0x40)[4:2].
- R3: The control word (`tgtSel` = 3, index 0) is written by any write whose word-aligned address is 0x70. It is read only by a read at exactly offset 0x70. Reads at 0x71 to 0x73 return 0 without any target strobe.
- R4: Reads at 0x60 to 0x6F and 0x74 to 0x7F return 0 with no target strobe. Writes there never raise `tgtWr`.
- R5: A write that is narrower than 4 bytes or offset within its word is handled in two cycles. In the first, `tgtRd` fetches the current word. In the next, `tgtWr` stores the merged word. Lane offset+k takes host byte k, and every other lane keeps its fetched value.
- R6: A narrow write at 0x60 to 0x6F fetches its merge word from the control register (`tgtRd` with `tgtSel` = 3) and is then dropped. At 0x74 to 0x7F the merge word is 0 and no fetch occurs.
- R7: A 4-byte aligned write issues exactly one `tgtWr`, carrying `hostWdata` unchanged, with no fetch.
- R8: Read data is the aligned word shifted right by 8 × (offset mod 4) bits and masked to 8 × size bits.
- R9: A size other than 1, 2 or 4, or an offset plus size beyond 4, completes with `hostErr` = 1 and `hostRdata` = 0, and with no target strobe.
- R10: `hostReady` is a one-cycle pulse. Counting from the clock edge that accepts the request, it comes 1 cycle later for an error, 2 for a read or a full write, and 3 for a merged write. `hostRdata` is 0 when a write completes.
- R11: While in reset and right after it, `hostReady`, `hostErr`, `tgtRd` and `tgtWr` are low and `hostRdata` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| hostReq | input | 1 | Access request, held until hostReady |
| hostWe | input | 1 | 1 = write, 0 = read |
| hostAddr | input | 7 | Byte offset in the window |
| hostSize | input | 3 | Access size in bytes |
| hostWdata | input | 32 | Write data, right-justified |
| hostReady | output | 1 | Completion pulse |
| hostRdata | output | 32 | Read data, right-justified |
| hostErr | output | 1 | Access rejected |
| tgtRd | output | 1 | Target word read strobe |
| tgtWr | output | 1 | Target word write strobe |
| tgtSel | output | 2 | Target select: 0 none, 1 core, 2 DMA, 3 control |
| tgtIdx | output | 4 | Word index inside the selected target |
| tgtWdata | output | 32 | Word to store |
| tgtRdata | input | 32 | Word returned by the selected target |

## Verification
The bench targets the lane arithmetic of merged writes at every offset and size. Junk is driven in the unused high bytes of `hostWdata`, so a merge that uses the wrong lanes clobbers neighbouring bytes or lets the junk through. It exercises the asymmetric control-word decode, including reads at 0x71 and narrow writes in the 0x60 to 0x6F hole. A design that decoded reads on the aligned address would return control data instead of 0. A design that merged from zero in the hole would not strobe the fetch.

Error accesses are followed by a read-back, so a rejected write that leaked a `tgtWr` shows up as corrupted data. Per-cycle strobe comparison catches any slip in latency or ordering between fetch and commit.

// File: rtl/swa_pkg.sv
package swa_pkg;

  typedef enum logic [1:0] {
    SEL_NONE = 2'd0,
    SEL_CORE = 2'd1,
    SEL_DMA  = 2'd2,
    SEL_CTL  = 2'd3
  } tgt_sel_e;

  typedef enum logic [1:0] {
    K_ERR   = 2'd0,
    K_READ  = 2'd1,
    K_WFULL = 2'd2,
    K_WPART = 2'd3
  } acc_kind_e;

  typedef struct packed {
    logic capture;
    logic fetch;
    logic commit;
    logic respond;
  } ctl_strobe_t;

endpackage

// File: rtl/swa_ctrl.sv
module swa_ctrl
  import swa_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        hostReq,
  input  acc_kind_e   liveKind,
  input  acc_kind_e   heldKind,
  output ctl_strobe_t stb
);

  typedef enum logic [1:0] {S_IDLE, S_FETCH, S_COMMIT, S_RESP} state_e;
  state_e state, stateNext;

  always_comb begin
    stateNext = state;
    stb       = '0;
    unique case (state)
      S_IDLE: if (hostReq) begin
        stb.capture = 1'b1;
        unique case (liveKind)
          K_ERR:   stateNext = S_RESP;
          K_WFULL: stateNext = S_COMMIT;
          default: stateNext = S_FETCH;
        endcase
      end
      S_FETCH: begin
        stb.fetch = 1'b1;
        stateNext = (heldKind == K_WPART) ? S_COMMIT : S_RESP;
      end
      S_COMMIT: begin
        stb.commit = 1'b1;
        stateNext  = S_RESP;
      end
      default: begin
        stb.respond = 1'b1;
        stateNext   = S_IDLE;
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) state <= S_IDLE;
    else       state <= stateNext;
  end

  // R10
  ready_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    stb.respond |=> !stb.respond);

  // R5
  merge_order_chk: assert property (@(posedge clk) disable iff (!rstN)
    (stb.commit && heldKind == K_WPART) |-> $past(stb.fetch));

endmodule

// File: rtl/swa_datapath.sv
module swa_datapath
  import swa_pkg::*;
#(
  parameter int ADDR_W    = 7,
  parameter int DATA_W    = 32,
  parameter int SIZE_W    = 3,
  parameter int IDX_W     = 4,
  parameter int CORE_END  = 'h40,
  parameter int DMA_END   = 'h60,
  parameter int CTL_OFF   = 'h70,
  parameter int MERGE_END = 'h74
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctl_strobe_t       stb,
  input  logic              hostWe,
  input  logic [ADDR_W-1:0] hostAddr,
  input  logic [SIZE_W-1:0] hostSize,
  input  logic [DATA_W-1:0] hostWdata,
  input  logic [DATA_W-1:0] tgtRdata,
  output acc_kind_e         liveKind,
  output acc_kind_e         heldKind,
  output logic [DATA_W-1:0] hostRdata,
  output logic              hostErr,
  output logic              tgtRd,
  output logic              tgtWr,
  output logic [1:0]        tgtSel,
  output logic [IDX_W-1:0]  tgtIdx,
  output logic [DATA_W-1:0] tgtWdata
);

  localparam int BYTES = DATA_W / 8;
  localparam int OFF_W = $clog2(BYTES);

  function automatic acc_kind_e classify(input logic we, input logic [ADDR_W-1:0] a,
                                         input logic [SIZE_W-1:0] sz);
    int off, s;
    bit legal;
    off   = int'(a[OFF_W-1:0]);
    s     = int'(sz);
    legal = (s != 0) && ((s & (s - 1)) == 0) && (s <= BYTES) && (off + s <= BYTES);
    if (!legal)     return K_ERR;
    if (!we)        return K_READ;
    if (s == BYTES) return K_WFULL;
    return K_WPART;
  endfunction

  logic [ADDR_W-1:0] addrQ;
  logic [SIZE_W-1:0] sizeQ;
  logic              weQ, errQ;
  logic [DATA_W-1:0] wdataQ, curQ, rdataQ;
  acc_kind_e         kindQ;

  assign liveKind  = classify(hostWe, hostAddr, hostSize);
  assign heldKind  = kindQ;
  assign hostRdata = rdataQ;
  assign hostErr   = errQ;

  // region decode on the latched request
  logic [OFF_W-1:0]  offQ;
  logic [ADDR_W-1:0] alignedQ;
  tgt_sel_e          rdSel, mgSel, wrSel, fetchSel;
  logic [IDX_W-1:0]  idxCalc;

  assign offQ     = addrQ[OFF_W-1:0];
  assign alignedQ = {addrQ[ADDR_W-1:OFF_W], {OFF_W{1'b0}}};

  always_comb begin
    rdSel   = SEL_NONE;
    mgSel   = SEL_NONE;
    wrSel   = SEL_NONE;
    idxCalc = '0;
    if (int'(alignedQ) < CORE_END) begin
      rdSel = SEL_CORE; mgSel = SEL_CORE; wrSel = SEL_CORE;
      idxCalc = IDX_W'(int'(alignedQ) >> OFF_W);
    end else if (int'(alignedQ) < DMA_END) begin
      rdSel = SEL_DMA; mgSel = SEL_DMA; wrSel = SEL_DMA;
      idxCalc = IDX_W'((int'(alignedQ) - CORE_END) >> OFF_W);
    end else begin
      if (int'(addrQ) == CTL_OFF)      rdSel = SEL_CTL;
      if (int'(alignedQ) == CTL_OFF)   wrSel = SEL_CTL;
      if (int'(alignedQ) < MERGE_END)  mgSel = SEL_CTL;
    end
  end

  assign fetchSel = weQ ? mgSel : rdSel;

  // lane merge and read extraction
  logic [DATA_W-1:0] curWord, wShift, rdShift, laneWin, sizeMask, merged;

  assign curWord = (fetchSel != SEL_NONE) ? tgtRdata : '0;
  assign wShift  = wdataQ << {offQ, 3'b000};
  assign rdShift = curWord >> {offQ, 3'b000};

  for (genvar ln = 0; ln < BYTES; ln++) begin : g_lane
    assign laneWin[8*ln +: 8]  = {8{(ln >= int'(offQ)) && (ln < int'(offQ) + int'(sizeQ))}};
    assign sizeMask[8*ln +: 8] = {8{ln < int'(sizeQ)}};
    assign merged[8*ln +: 8]   = laneWin[8*ln] ? wShift[8*ln +: 8] : curQ[8*ln +: 8];
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      addrQ <= '0; sizeQ <= '0; weQ <= 1'b0; wdataQ <= '0;
      kindQ <= K_ERR; curQ <= '0; rdataQ <= '0; errQ <= 1'b0;
    end else begin
      if (stb.capture) begin
        addrQ  <= hostAddr;
        sizeQ  <= hostSize;
        weQ    <= hostWe;
        wdataQ <= hostWdata;
        kindQ  <= liveKind;
        errQ   <= (liveKind == K_ERR);
        rdataQ <= '0;
      end
      if (stb.fetch) begin
        curQ <= curWord;
        if (!weQ) rdataQ <= rdShift & sizeMask;
      end
    end
  end

  always_comb begin
    tgtRd    = 1'b0;
    tgtWr    = 1'b0;
    tgtSel   = SEL_NONE;
    tgtIdx   = '0;
    tgtWdata = merged;
    if (stb.fetch) begin
      tgtSel = fetchSel;
      tgtIdx = idxCalc;
      tgtRd  = (fetchSel != SEL_NONE);
    end else if (stb.commit) begin
      tgtSel = wrSel;
      tgtIdx = idxCalc;
      tgtWr  = (wrSel != SEL_NONE);
    end
  end

  // R8
  rdata_width_chk: assert property (@(posedge clk) disable iff (!rstN)
    (stb.respond && !weQ && !errQ && int'(sizeQ) < BYTES)
      |-> ((hostRdata >> {sizeQ, 3'b000}) == '0));

endmodule

// File: rtl/subword_window_adapter.sv
module subword_window_adapter
  import swa_pkg::*;
#(
  parameter int ADDR_W = 7,
  parameter int DATA_W = 32,
  parameter int SIZE_W = 3,
  parameter int IDX_W  = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              hostReq,
  input  logic              hostWe,
  input  logic [ADDR_W-1:0] hostAddr,
  input  logic [SIZE_W-1:0] hostSize,
  input  logic [DATA_W-1:0] hostWdata,
  output logic              hostReady,
  output logic [DATA_W-1:0] hostRdata,
  output logic              hostErr,
  output logic              tgtRd,
  output logic              tgtWr,
  output logic [1:0]        tgtSel,
  output logic [IDX_W-1:0]  tgtIdx,
  output logic [DATA_W-1:0] tgtWdata,
  input  logic [DATA_W-1:0] tgtRdata
);

  ctl_strobe_t stb;
  acc_kind_e   liveKind, heldKind;

  swa_ctrl ctrl_i (
    .clk(clk), .rstN(rstN), .hostReq(hostReq),
    .liveKind(liveKind), .heldKind(heldKind), .stb(stb)
  );

  swa_datapath #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .SIZE_W(SIZE_W), .IDX_W(IDX_W)
  ) dp_i (
    .clk(clk), .rstN(rstN), .stb(stb),
    .hostWe(hostWe), .hostAddr(hostAddr), .hostSize(hostSize), .hostWdata(hostWdata),
    .tgtRdata(tgtRdata), .liveKind(liveKind), .heldKind(heldKind),
    .hostRdata(hostRdata), .hostErr(hostErr),
    .tgtRd(tgtRd), .tgtWr(tgtWr), .tgtSel(tgtSel), .tgtIdx(tgtIdx), .tgtWdata(tgtWdata)
  );

  assign hostReady = stb.respond;

  // R9
  err_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    (hostReady && hostErr) |-> (!$past(tgtRd) && !$past(tgtWr)));

  // R10
  wr_then_ready_chk: assert property (@(posedge clk) disable iff (!rstN)
    tgtWr |=> hostReady);

endmodule

// File: tb/subword_window_adapter_tb_top.sv
`timescale 1ns/1ps
module subword_window_adapter_tb_top;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        hostReq = 1'b0, hostWe = 1'b0;
  logic [6:0]  hostAddr = '0;
  logic [2:0]  hostSize = '0;
  logic [31:0] hostWdata = '0;
  logic        hostReady, hostErr, tgtRd, tgtWr;
  logic [31:0] hostRdata, tgtWdata, tgtRdata;
  logic [1:0]  tgtSel;
  logic [3:0]  tgtIdx;

  int compared = 0;
  int mismatched = 0;

  // bench-owned targets
  logic [31:0] coreM [16];
  logic [31:0] dmaM  [8];
  logic [31:0] ctlM;

  always #2.5 clk = ~clk;

  subword_window_adapter dut_i (
    .clk(clk), .rstN(rstN), .hostReq(hostReq), .hostWe(hostWe),
    .hostAddr(hostAddr), .hostSize(hostSize), .hostWdata(hostWdata),
    .hostReady(hostReady), .hostRdata(hostRdata), .hostErr(hostErr),
    .tgtRd(tgtRd), .tgtWr(tgtWr), .tgtSel(tgtSel), .tgtIdx(tgtIdx),
    .tgtWdata(tgtWdata), .tgtRdata(tgtRdata)
  );

  always_comb begin
    case (tgtSel)
      2'd1:    tgtRdata = coreM[tgtIdx];
      2'd2:    tgtRdata = dmaM[tgtIdx[2:0]];
      2'd3:    tgtRdata = ctlM;
      default: tgtRdata = 32'h0;
    endcase
  end

  always @(posedge clk) begin
    if (tgtWr) begin
      case (tgtSel)
        2'd1: coreM[tgtIdx] <= tgtWdata;
        2'd2: dmaM[tgtIdx[2:0]] <= tgtWdata;
        2'd3: ctlM <= tgtWdata;
        default: ;
      endcase
    end
  end

  function automatic logic [31:0] mread(int sel, int idx);
    case (sel)
      1: return coreM[idx];
      2: return dmaM[idx & 7];
      3: return ctlM;
      default: return 32'h0;
    endcase
  endfunction

  task automatic cmp(string tag, string what, longint act, longint exp);
    compared++;
    if (act != exp) begin
      mismatched++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  // Behavioural reference: per-cycle expectations for one access.
  task automatic access(string tag, int addr, int size, bit we, logic [31:0] wd);
    int off, aligned, rs, ms, ws, idx, nCyc;
    bit legal;
    logic [63:0] cur, rexp, mask, merged;
    bit eRd[4], eWr[4], eRdy[4];
    int eSel[4];
    logic [31:0] eWd[4];
    off = addr & 3;
    aligned = addr & 'h7C;
    rs = 0; ms = 0; ws = 0; idx = 0;
    if (addr < 'h40) begin rs = 1; ms = 1; ws = 1; idx = aligned >> 2; end
    else if (addr < 'h60) begin rs = 2; ms = 2; ws = 2; idx = (aligned - 'h40) >> 2; end
    else begin
      if (addr == 'h70) rs = 3;
      if (aligned == 'h70) ws = 3;
      if (aligned < 'h74) ms = 3;
    end
    legal = (size == 1 || size == 2 || size == 4) && (off + size <= 4);
    mask = (64'h1 << (8 * size)) - 1;
    for (int c = 0; c < 4; c++) begin eRd[c] = 0; eWr[c] = 0; eRdy[c] = 0; eSel[c] = 0; eWd[c] = 0; end
    rexp = 0;
    if (!legal) begin
      nCyc = 1;
    end else if (!we) begin
      nCyc = 2;
      eRd[1] = (rs != 0); eSel[1] = rs;
      rexp = ((64'(mread(rs, idx)) >> (8 * off)) & mask);
    end else if (size == 4) begin
      nCyc = 2;
      eWr[1] = (ws != 0); eSel[1] = ws; eWd[1] = wd;
    end else begin
      nCyc = 3;
      eRd[1] = (ms != 0); eSel[1] = ms;
      cur = 64'(mread(ms, idx));
      merged = cur;
      for (int b = 0; b < 4; b++)
        if (b >= off && b < off + size)
          merged[8*b +: 8] = wd[8*(b-off) +: 8];
      eWr[2] = (ws != 0); eSel[2] = ws; eWd[2] = merged[31:0];
    end
    eRdy[nCyc] = 1;
    hostReq = 1; hostWe = we; hostAddr = 7'(addr); hostSize = 3'(size); hostWdata = wd;
    for (int c = 1; c <= nCyc; c++) begin
      @(posedge clk); @(negedge clk);
      cmp(tag, "tgtRd", tgtRd, eRd[c]);
      cmp(tag, "tgtWr", tgtWr, eWr[c]);
      cmp(tag, "hostReady", hostReady, eRdy[c]);
      if (eRd[c] || eWr[c]) begin
        cmp(tag, "tgtSel", tgtSel, eSel[c]);
        if (eSel[c] == 1 || eSel[c] == 2) cmp(tag, "tgtIdx", tgtIdx, idx);
      end
      if (eWr[c]) cmp(tag, "tgtWdata", tgtWdata, eWd[c]);
      if (eRdy[c]) begin
        cmp(tag, "hostErr", hostErr, !legal);
        cmp(tag, "hostRdata", hostRdata, rexp);
      end
    end
    hostReq = 0;
    @(posedge clk); @(negedge clk);
    cmp(tag, "idle tgtRd", tgtRd, 0);
    cmp(tag, "idle tgtWr", tgtWr, 0);
    cmp(tag, "idle hostReady", hostReady, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    mismatched++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    for (int i = 0; i < 16; i++) coreM[i] = 32'hC0000000 + i * 32'h00010203;
    for (int i = 0; i < 8; i++)  dmaM[i]  = 32'hD0000000 + i * 32'h00102030;
    ctlM = 32'h00001000;
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R11 reset state
    cmp("R11", "hostReady", hostReady, 0);
    cmp("R11", "hostErr", hostErr, 0);
    cmp("R11", "hostRdata", hostRdata, 0);
    cmp("R11", "tgtRd", tgtRd, 0);
    cmp("R11", "tgtWr", tgtWr, 0);
    rstN = 1;
    @(negedge clk);
    cmp("R11", "post reset hostReady", hostReady, 0);

    // R1 R8: every core word, full and sub-word reads
    for (int i = 0; i < 16; i++) access("R1", i * 4, 4, 0, 0);
    access("R8", 'h0D, 1, 0, 0);
    access("R8", 'h1E, 2, 0, 0);
    // R7 full aligned writes
    access("R7", 'h08, 4, 1, 32'h11223344);
    access("R7", 'h44, 4, 1, 32'hA5A55A5A);
    // R2 DMA mapping
    for (int i = 0; i < 8; i++) access("R2", 'h40 + i * 4, 4, 0, 0);
    access("R2", 'h46, 2, 0, 0);
    // R5 merged writes, junk in upper bytes
    access("R5", 'h09, 1, 1, 32'hFFFFFFEE);
    access("R5", 'h0B, 1, 0, 0);
    access("R5", 'h0A, 2, 1, 32'h5A5ABEEF);
    access("R5", 'h08, 4, 0, 0);
    access("R5", 'h0C, 2, 1, 32'h77771234);
    access("R5", 'h5F, 1, 1, 32'h000000AB);
    access("R5", 'h5C, 4, 0, 0);
    access("R5", 'h20, 1, 1, 32'h9999993C);
    access("R5", 'h20, 4, 0, 0);
    // R3 control word
    access("R3", 'h70, 4, 1, 32'hCAFEF00D);
    access("R3", 'h73, 1, 1, 32'hFFFFFF42);
    access("R3", 'h71, 2, 1, 32'hFFFF6677);
    access("R3", 'h70, 4, 0, 0);
    access("R3", 'h71, 1, 0, 0);
    access("R3", 'h72, 2, 0, 0);
    // R6 R4 holes
    access("R6", 'h64, 1, 1, 32'h000000FF);
    access("R6", 'h6A, 2, 1, 32'h0000FFFF);
    access("R6", 'h78, 2, 1, 32'h00001111);
    access("R4", 'h64, 4, 1, 32'h12345678);
    access("R4", 'h7C, 4, 1, 32'h12345678);
    access("R4", 'h64, 4, 0, 0);
    access("R4", 'h7F, 1, 0, 0);
    access("R4", 'h70, 4, 0, 0);
    // R9 errors then read-back
    access("R9", 'h00, 3, 1, 32'hDEADBEEF);
    access("R9", 'h00, 0, 1, 32'hDEADBEEF);
    access("R9", 'h02, 4, 1, 32'hDEADBEEF);
    access("R9", 'h03, 2, 1, 32'hDEADBEEF);
    access("R9", 'h40, 7, 0, 0);
    access("R9", 'h01, 4, 0, 0);
    access("R9", 'h00, 4, 0, 0);
    // R10 back-to-back latency already checked per cycle; one more mix
    access("R10", 'h31, 1, 1, 32'h00000055);
    access("R10", 'h30, 4, 0, 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

endmodule